// File: doc/BRIEF.md
# Seconds Counter with Alarm

A memory-mapped real-time clock. A 32-bit seconds count advances once each second, timed by a prescaler that divides the system clock by `CLK_HZ`. Software can read the count, load a new value, and set an alarm value. When the count becomes equal to the alarm value, an alarm flag is raised. If the alarm is unmasked, a level interrupt follows the flag.

The block sits on a simple single-cycle register bus with select, write, a 12-bit byte address, write data and combinational read data. A write takes effect at the clock edge where `sel` and `wr` are both high. Read data reflects the register state in the same cycle. Eight identification words occupy the top of the 4 KB window.

Top module: `rtc_alarm`

## Requirements
- R1: After reset the count, alarm value, load value, mask and alarm flag all read 0, and `irq` is low.
- R2: The count rises by one every `CLK_HZ` clock cycles and wraps from 0xFFFFFFFF to 0. It does not change in any other cycle unless it is loaded.
- R3: A write to word 0x08 sets the count to the written value and restarts the prescaler, so the next increment comes `CLK_HZ` cycles after the write edge. Word 0x08 reads back the last value written there.
- R4: When an increment makes the count equal to the alarm value (word 0x04), the alarm flag (bit 0 of word 0x14) is set.
- R5: A write to the alarm value or to the load register compares the new count with the new alarm value at once. If they are equal, the flag is set at that edge.
- R6: The mask (word 0x10) keeps only bit 0 of the written data. Word 0x18 reads flag AND mask, and `irq` equals that value.
- R7: A write of any data to word 0x1C clears the flag. If a match occurs in the same cycle, setting the flag wins over clearing it.
- R8: Word 0x0C always reads 1, and writes to it have no effect.
- R9: Writes to words 0x00, 0x14 and 0x18 and to unmapped offsets have no effect. Word 0x1C and unmapped offsets read 0.
- R10: Offsets 0xFE0 through 0xFFC read the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word, in rising address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe (high = write, low = read) |
| addr | input | 12 | Byte address inside the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt: flag AND mask |

## Verification
Reads are combinational, so a register written at an edge shows its new value from the next cycle on. The bench therefore drives inputs on the falling edge and samples one falling edge after the write edge. A load restarts the prescaler, which makes the first increment land exactly `CLK_HZ` edges after the load edge. The bench counts edges from the load, checks the count one edge before that point and again on it, and times a clear write to land on the increment edge to test set-over-clear priority. Alarm flag and `irq` changes caused by an increment follow from the same edge count.

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int PW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] PLAST = PW'(CLK_HZ - 1);

  logic [PW-1:0] pre;
  logic [31:0]   cnt, mr, lr;
  logic          mask, raw;

  wire [9:0] word  = addr[11:2];
  wire       unused_ok = &{1'b0, addr[1:0]};
  wire       we    = sel & wr;
  wire       ld_wr = we & (word == 10'h002);
  wire       mr_wr = we & (word == 10'h001);
  wire       im_wr = we & (word == 10'h004);
  wire       cl_wr = we & (word == 10'h007);
  wire       tick  = (pre == PLAST);

  wire [31:0] cnt_n = ld_wr ? wdata : (tick ? cnt + 32'd1 : cnt);
  wire [31:0] mr_n  = mr_wr ? wdata : mr;
  wire        hit   = (tick | ld_wr | mr_wr) & (cnt_n == mr_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      cnt  <= '0;
      mr   <= '0;
      lr   <= '0;
      mask <= 1'b0;
      raw  <= 1'b0;
    end else begin
      pre <= (ld_wr || tick) ? '0 : pre + 1'b1;
      cnt <= cnt_n;
      mr  <= mr_n;
      if (ld_wr) lr <= wdata;
      if (im_wr) mask <= wdata[0];
      if (hit) raw <= 1'b1;
      else if (cl_wr) raw <= 1'b0;
    end
  end

  assign irq = raw & mask;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    rdata = '0;
    case (word)
      10'h000: rdata = cnt;
      10'h001: rdata = mr;
      10'h002: rdata = lr;
      10'h003: rdata = 32'd1;
      10'h004: rdata = {31'd0, mask};
      10'h005: rdata = {31'd0, raw};
      10'h006: rdata = {31'd0, irq};
      default: if (addr[11:5] == 7'h7F) rdata = {24'd0, id_byte(addr[4:2])};
    endcase
  end
endmodule

module rtc_alarm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        wr,
  input logic [11:0] addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        irq,
  input logic [31:0] cnt,
  input logic        tick,
  input logic        mask
);
  wire ld = sel && wr && addr[11:2] == 10'h002;

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(wdata));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !tick) |=> $stable(cnt));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld) |=> cnt == $past(cnt) + 32'd1);
  assert_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr[11:2] == 10'h003) |-> rdata == 32'd1);
  assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr[11:2] == 10'h006) |-> rdata == {31'd0, irq});
  assert_maskbit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr[11:2] == 10'h004) |=> mask == $past(wdata[0]));
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |-> !irq);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr[11:2] == 10'h007 && !tick) |=> !irq);
endmodule

bind rtc_alarm rtc_alarm_chk u_chk (.*);

// File: tb/rtc_alarm_test.sv
module rtc_alarm_test;
  localparam int HZ = 10;
  logic clk = 0, rst_n = 0, sel = 0, wr = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  logic irq;
  int n_chk = 0, n_bad = 0;

  rtc_alarm #(.CLK_HZ(HZ)) uut (.clk, .rst_n, .sel, .wr, .addr, .wdata, .rdata, .irq);

  always #5 clk = ~clk;

  localparam logic [43:0] VEC [0:11] = '{
    {12'hFE0, 32'h31}, {12'hFE4, 32'h10}, {12'hFE8, 32'h14}, {12'hFEC, 32'h00},
    {12'hFF0, 32'h0D}, {12'hFF4, 32'hF0}, {12'hFF8, 32'h05}, {12'hFFC, 32'hB1},
    {12'h00C, 32'h1},  {12'h01C, 32'h0},  {12'h100, 32'h0},  {12'h020, 32'h0}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    sel = 1; wr = 0; addr = a; #1; d = rdata; sel = 0;
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(12'h000, v); chk("R1 count", v, 0);
    rd(12'h004, v); chk("R1 match", v, 0);
    rd(12'h008, v); chk("R1 load", v, 0);
    rd(12'h010, v); chk("R1 mask", v, 0);
    rd(12'h014, v); chk("R1 raw", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R10 / R8 / R9 table walk
    for (int i = 0; i < 12; i++) begin
      rd(VEC[i][43:32], v);
      chk("R10 R8 R9 table", v, VEC[i][31:0]);
    end

    // R3 load and prescaler restart, R2 step
    wreg(12'h004, 32'h0000_0105);
    wreg(12'h010, 32'h1);
    wreg(12'h008, 32'h0000_0100);
    rd(12'h008, v); chk("R3 load readback", v, 32'h100);
    repeat (9) @(posedge clk); @(negedge clk);
    rd(12'h000, v); chk("R3 no tick before full period", v, 32'h100);
    @(posedge clk); @(negedge clk);
    rd(12'h000, v); chk("R2 tick after period", v, 32'h101);

    // R9 ignored writes
    wreg(12'h008, 32'h0000_0200);
    wreg(12'h000, 32'h1234);
    rd(12'h000, v); chk("R9 count write ignored", v, 32'h200);
    wreg(12'h014, 32'h1); wreg(12'h018, 32'h1);
    rd(12'h014, v); chk("R9 raw write ignored", v, 0);
    wreg(12'h00C, 32'h0);
    rd(12'h00C, v); chk("R8 control after write", v, 1);
    wreg(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, v); chk("R9 unmapped read", v, 0);
    rd(12'h004, v); chk("R9 unmapped write no effect", v, 32'h105);

    // R4 match by tick
    wreg(12'h004, 32'h0000_0301);
    wreg(12'h008, 32'h0000_0300);
    rd(12'h014, v); chk("R4 raw before match", v, 0);
    repeat (9) @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd(12'h014, v); chk("R4 raw after match", v, 1);
    chk("R6 irq with mask", {31'd0, irq}, 1);
    rd(12'h018, v); chk("R6 masked status", v, 1);

    // R6 mask bit 0 only
    wreg(12'h010, 32'hFFFF_FFFE);
    rd(12'h010, v); chk("R6 mask bit0 clear", v, 0);
    chk("R6 irq masked off", {31'd0, irq}, 0);
    rd(12'h018, v); chk("R6 masked zero", v, 0);
    rd(12'h014, v); chk("R6 raw kept", v, 1);
    wreg(12'h010, 32'h3);
    rd(12'h010, v); chk("R6 mask holds bit0", v, 1);

    // R7 clear any value
    wreg(12'h01C, 32'h0);
    rd(12'h014, v); chk("R7 clear with zero data", v, 0);
    chk("R7 irq low", {31'd0, irq}, 0);

    // R2 wrap, R5 immediate compare on match write
    wreg(12'h004, 32'h5);
    wreg(12'h008, 32'hFFFF_FFFF);
    repeat (9) @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd(12'h000, v); chk("R2 wrap to zero", v, 0);
    rd(12'h014, v); chk("R2 no false match", v, 0);
    wreg(12'h004, 32'h0);
    rd(12'h014, v); chk("R5 match write immediate", v, 1);
    wreg(12'h01C, 32'hABCD);
    rd(12'h014, v); chk("R7 clear", v, 0);

    // R5 immediate compare on load
    wreg(12'h004, 32'h50);
    wreg(12'h008, 32'h50);
    rd(12'h014, v); chk("R5 load immediate", v, 1);
    wreg(12'h01C, 32'h1);

    // R7 set wins over clear in same cycle
    wreg(12'h004, 32'h701);
    wreg(12'h008, 32'h700);
    repeat (9) @(posedge clk);
    wreg(12'h01C, 32'h1);
    rd(12'h000, v); chk("R7 tick on clear edge", v, 32'h701);
    rd(12'h014, v); chk("R7 set beats clear", v, 1);
    chk("R7 irq stays", {31'd0, irq}, 1);

    finish_run();
  end
endmodule